// File: doc/BRIEF.md
# CompactFlash True IDE bus cycle generator

This block runs single read and write cycles on an asynchronous parallel bus that connects to a CompactFlash card in True IDE mode. A requester raises `req_i` with an address, a direction, a data width and write data. It holds these inputs until `ack_o` is high. The block then drives chip select, the read or write strobe, the address and the data lanes with a fixed shape, counted in core clock ticks. It returns the read data and an error flag in the same tick as `ack_o`.

The timing is set by compact encoded fields:
- a 6-bit setup field,
- a 7-bit strobe pulse field,
- a 7-bit chip-select pulse field,
- a 9-bit cycle field.

Each field decodes piecewise into a tick count. Other controls:
- **Data-float count:** holds the bus idle after a read.
- **Ready mode:** lets the card stretch the strobe through a synchronized ready input.
- **Stretch limit:** a programmable limit ends a stretch that runs too long, and the access is flagged as failed.

Task-file registers are reached with narrow (8-bit) requests and the data register with wide (16-bit) requests. The command block sits at byte offset 0xC00000 and the alternate-status register at 0xE00006.

Top module: `cf_bus_cycle_gen`

## Requirements
- R1: Decoded setup S = 128*setup[5] + setup[4:0], strobe pulse P = 256*pulse[6] + pulse[5:0], cycle C = 256*cycle[8:7] + cycle[6:0], chip-select length K = 256*cs[6] + cs[5:0]. Tick 0 is the first clock period after the edge that accepts a request. The strobe is low during ticks t with S <= t < S+P.
- R2: Without stretching, an access lasts L = max(C, S+P, 1) ticks. `ack_o` is high only during the last tick.
- R3: `bus_cs_no` is low exactly during ticks t < K of an access.
- R4: `bus_rd_no` falls only on reads and `bus_wr_no` only on writes. Both strobes are never low together.
- R5: On writes, `bus_data_oe_o[0]` is high for every tick of the access. `bus_data_oe_o[1]` is high for every tick only when `req_wide_i` is 1. `bus_data_o` carries the write data, with the upper byte 0 on narrow writes. On reads and in idle, both enables are 0.
- R6: In the `ack_o` tick of a read, `rdata_o` equals the value of `bus_data_i` in the last strobe tick. The upper byte is 0 on narrow reads.
- R7: After a read, the number of idle ticks before the next access begins is max(1, F), where F is the data-float count (0 to 15). After a write it is 1.
- R8: `bus_rdy_i` passes through two flops, so a change in tick X is seen in tick X+2. With ready mode on and ready seen low in the last strobe tick, every output holds and the access is stretched by one tick per such tick.
- R9: After T stretched ticks, where T is `cfg_timeout_i`, the access continues and `err_o` is high in its `ack_o` tick. With ready mode off, `bus_rdy_i` has no effect on the cycle shape or on `err_o`.
- R10: During and after reset, `bus_cs_no`, `bus_rd_no` and `bus_wr_no` are high, the data enables are 0 and `ack_o` is 0.
- R11: `bus_addr_o` equals the request address for every tick of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_setup_i | input | 6 | Encoded strobe setup |
| cfg_pulse_i | input | 7 | Encoded strobe pulse |
| cfg_cycle_i | input | 9 | Encoded cycle length |
| cfg_cs_pulse_i | input | 7 | Encoded chip-select length |
| cfg_float_i | input | FLT_W | Idle ticks after a read |
| cfg_rdy_en_i | input | 1 | Ready stretch enable |
| cfg_timeout_i | input | TMO_W | Stretch limit in ticks |
| req_i | input | 1 | Access request, held until ack |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wide_i | input | 1 | 1 = 16-bit, 0 = 8-bit |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 16 | Write data |
| ack_o | output | 1 | High in the last tick of an access |
| rdata_o | output | 16 | Read data, valid with ack |
| err_o | output | 1 | Stretch limit reached, valid with ack |
| bus_cs_no | output | 1 | Chip select, active low |
| bus_rd_no | output | 1 | Read strobe, active low |
| bus_wr_no | output | 1 | Write strobe, active low |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_data_o | output | 16 | Bus write data |
| bus_data_oe_o | output | 2 | Per-byte-lane output enable |
| bus_data_i | input | 16 | Bus read data |
| bus_rdy_i | input | 1 | Card ready, active high |

## Verification
Every pin is a function of the tick index counted from the accepting edge. `ack_o`, `err_o` and `rdata_o` are due in the final tick itself, not a clock later. The bench therefore samples once per tick, just after the falling edge. It compares each pin against a tick model that runs the decoded S, P, C, K and L in parallel with the design. A ready change made in tick X is applied to the model from tick X+2. The float gap is measured as the count of falling-edge samples with chip select high between the read's final tick and the next access.

// File: rtl/cfb_pkg.sv
package cfb_pkg;
  localparam int TICK_W = 11;
  localparam int DATA_W = 16;
  localparam int LANE_W = 8;
  localparam int LANES  = DATA_W / LANE_W;

  typedef logic [TICK_W-1:0] tick_t;

  typedef struct packed {
    tick_t setup;       // first strobe tick
    tick_t strobe_end;  // first tick after strobe
    tick_t cs_len;      // chip-select ticks
    tick_t len;         // unstretched access length
  } cfb_tim_t;

  function automatic tick_t dec_setup(input logic [5:0] c);
    return tick_t'({c[5], 7'b0}) + tick_t'(c[4:0]);
  endfunction

  function automatic tick_t dec_pulse(input logic [6:0] c);
    return tick_t'({c[6], 8'b0}) + tick_t'(c[5:0]);
  endfunction

  function automatic tick_t dec_cycle(input logic [8:0] c);
    return tick_t'({c[8:7], 8'b0}) + tick_t'(c[6:0]);
  endfunction
endpackage

// File: rtl/cfb_timing_dec.sv
module cfb_timing_dec
  import cfb_pkg::*;
(
  input  logic [5:0] setup_i,
  input  logic [6:0] pulse_i,
  input  logic [8:0] cycle_i,
  input  logic [6:0] cs_pulse_i,
  output cfb_tim_t   tim_o
);
  tick_t s_dec, p_dec, c_dec, end_dec, len_a;

  always_comb begin
    s_dec   = dec_setup(setup_i);
    p_dec   = dec_pulse(pulse_i);
    c_dec   = dec_cycle(cycle_i);
    end_dec = s_dec + p_dec;
    len_a   = (c_dec > end_dec) ? c_dec : end_dec;
    tim_o.setup      = s_dec;
    tim_o.strobe_end = end_dec;
    tim_o.cs_len     = dec_pulse(cs_pulse_i);
    tim_o.len        = (len_a == '0) ? tick_t'(1) : len_a;
  end

  always_comb begin
    a_r2_len_covers_strobe: assert (tim_o.len >= tim_o.strobe_end && tim_o.len != '0);
  end
endmodule

// File: rtl/cfb_rdy_sync.sv
module cfb_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q[k] <= 1'b0;
      else         sr_q[k] <= (k == 0) ? d_i : sr_q[(k == 0) ? 0 : k-1];
    end
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/cfb_sequencer.sv
module cfb_sequencer
  import cfb_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int TMO_W  = 8,
  parameter int FLT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cfb_tim_t          tim_i,
  input  logic [FLT_W-1:0]  float_i,
  input  logic              rdy_en_i,
  input  logic [TMO_W-1:0]  timeout_i,
  input  logic              rdy_i,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic              req_wide_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              cs_no,
  output logic              rd_no,
  output logic              wr_no,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [LANES-1:0]  data_oe_o,
  input  logic [DATA_W-1:0] data_i
);
  logic              busy_q, we_q, wide_q, err_q;
  tick_t             t_q;
  logic [TMO_W-1:0]  w_q;
  logic [FLT_W-1:0]  flt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rd_q, rd_raw;
  logic              strb, strb_last, not_rdy, stall, tmo, last, start;

  assign strb      = busy_q && (t_q >= tim_i.setup) && (t_q < tim_i.strobe_end);
  assign strb_last = strb && (t_q == tim_i.strobe_end - tick_t'(1));
  assign not_rdy   = rdy_en_i && strb_last && !rdy_i;
  assign stall     = not_rdy && (w_q != timeout_i);
  assign tmo       = not_rdy && (w_q == timeout_i);
  assign last      = busy_q && (t_q == tim_i.len - tick_t'(1)) && !stall;
  assign start     = !busy_q && req_i && (flt_q <= FLT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      wide_q  <= 1'b0;
      err_q   <= 1'b0;
      t_q     <= '0;
      w_q     <= '0;
      flt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rd_q    <= '0;
    end else begin
      if (strb && !we_q) rd_q <= data_i;
      if (!busy_q) begin
        if (flt_q != '0) flt_q <= flt_q - FLT_W'(1);
        if (start) begin
          busy_q  <= 1'b1;
          t_q     <= '0;
          w_q     <= '0;
          err_q   <= 1'b0;
          we_q    <= req_we_i;
          wide_q  <= req_wide_i;
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
        end
      end else if (stall) begin
        w_q <= w_q + TMO_W'(1);
      end else begin
        if (tmo) err_q <= 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          flt_q  <= we_q ? '0 : float_i;
        end else begin
          t_q <= t_q + tick_t'(1);
        end
      end
    end
  end

  assign rd_raw = (strb && !we_q) ? data_i : rd_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic lane_on;
    assign lane_on = (l == 0) || wide_q;
    assign data_oe_o[l] = busy_q && we_q && lane_on;
    assign data_o[l*LANE_W +: LANE_W]  = lane_on ? wdata_q[l*LANE_W +: LANE_W] : '0;
    assign rdata_o[l*LANE_W +: LANE_W] = lane_on ? rd_raw[l*LANE_W +: LANE_W]  : '0;
  end

  assign ack_o  = last;
  assign err_o  = last && (err_q || tmo);
  assign cs_no  = !(busy_q && (t_q < tim_i.cs_len));
  assign rd_no  = !(strb && !we_q);
  assign wr_no  = !(strb && we_q);
  assign addr_o = addr_q;

  a_r2_ack_ends_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !busy_q);
  a_r7_float_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !we_q && float_i >= FLT_W'(2)) |=> !busy_q ##1 !busy_q);
  a_r8_stretch_holds_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall |=> ($stable(rd_no) && $stable(wr_no) && $stable(cs_no)));
  a_r10_idle_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (cs_no && rd_no && wr_no && data_oe_o == '0));
  a_r11_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(addr_o));
endmodule

// File: rtl/cf_bus_cycle_gen.sv
module cf_bus_cycle_gen
  import cfb_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int TMO_W       = 8,
  parameter int FLT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [5:0]        cfg_setup_i,
  input  logic [6:0]        cfg_pulse_i,
  input  logic [8:0]        cfg_cycle_i,
  input  logic [6:0]        cfg_cs_pulse_i,
  input  logic [FLT_W-1:0]  cfg_float_i,
  input  logic              cfg_rdy_en_i,
  input  logic [TMO_W-1:0]  cfg_timeout_i,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic              req_wide_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [15:0]       req_wdata_i,
  output logic              ack_o,
  output logic [15:0]       rdata_o,
  output logic              err_o,
  output logic              bus_cs_no,
  output logic              bus_rd_no,
  output logic              bus_wr_no,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [15:0]       bus_data_o,
  output logic [1:0]        bus_data_oe_o,
  input  logic [15:0]       bus_data_i,
  input  logic              bus_rdy_i
);
  cfb_tim_t tim;
  logic     rdy_s;

  cfb_timing_dec u_dec (
    .setup_i    (cfg_setup_i),
    .pulse_i    (cfg_pulse_i),
    .cycle_i    (cfg_cycle_i),
    .cs_pulse_i (cfg_cs_pulse_i),
    .tim_o      (tim)
  );

  cfb_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (bus_rdy_i),
    .q_o    (rdy_s)
  );

  cfb_sequencer #(.ADDR_W(ADDR_W), .TMO_W(TMO_W), .FLT_W(FLT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tim_i       (tim),
    .float_i     (cfg_float_i),
    .rdy_en_i    (cfg_rdy_en_i),
    .timeout_i   (cfg_timeout_i),
    .rdy_i       (rdy_s),
    .req_i       (req_i),
    .req_we_i    (req_we_i),
    .req_wide_i  (req_wide_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .ack_o       (ack_o),
    .rdata_o     (rdata_o),
    .err_o       (err_o),
    .cs_no       (bus_cs_no),
    .rd_no       (bus_rd_no),
    .wr_no       (bus_wr_no),
    .addr_o      (bus_addr_o),
    .data_o      (bus_data_o),
    .data_oe_o   (bus_data_oe_o),
    .data_i      (bus_data_i)
  );

  a_r4_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!bus_rd_no && !bus_wr_no));
  a_r9_err_needs_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (ack_o && cfg_rdy_en_i));
endmodule

// File: tb/cf_bus_cycle_gen_tb.sv
module cf_bus_cycle_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [5:0]  cfg_setup = '0;
  logic [6:0]  cfg_pulse = 7'd1;
  logic [8:0]  cfg_cycle = '0;
  logic [6:0]  cfg_cs = 7'd4;
  logic [3:0]  cfg_float = '0;
  logic        cfg_rdy_en = 1'b0;
  logic [7:0]  cfg_timeout = 8'd10;
  logic        req = 1'b0, req_we = 1'b0, req_wide = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        ack, err, cs_n, rd_n, wr_n;
  logic [15:0] rdata, bdata_o, bdata_i;
  logic [23:0] baddr;
  logic [1:0]  boe;
  logic        brdy = 1'b1;

  int nchk = 0;
  int nfail = 0;

  cf_bus_cycle_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_setup_i(cfg_setup), .cfg_pulse_i(cfg_pulse), .cfg_cycle_i(cfg_cycle),
    .cfg_cs_pulse_i(cfg_cs), .cfg_float_i(cfg_float), .cfg_rdy_en_i(cfg_rdy_en),
    .cfg_timeout_i(cfg_timeout),
    .req_i(req), .req_we_i(req_we), .req_wide_i(req_wide), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata),
    .ack_o(ack), .rdata_o(rdata), .err_o(err),
    .bus_cs_no(cs_n), .bus_rd_no(rd_n), .bus_wr_no(wr_n), .bus_addr_o(baddr),
    .bus_data_o(bdata_o), .bus_data_oe_o(boe), .bus_data_i(bdata_i), .bus_rdy_i(brdy)
  );

  function automatic int dset(input int b); return ((b >> 5) & 1) * 128 + (b & 31); endfunction
  function automatic int dpul(input int b); return ((b >> 6) & 1) * 256 + (b & 63); endfunction
  function automatic int dcyc(input int b); return ((b >> 7) & 3) * 256 + (b & 127); endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // rise: -1 ready stays high, -2 stays low, >=0 goes high in that tick
  task automatic do_access(input bit we, input bit wide, input logic [23:0] addr,
                           input logic [15:0] wd, input int rise);
    int s, p, c, k, l, tmax, t, w, i, last_rd, exp_rd, exp_wd;
    bit en, rs, strb, lst, hold, tmo, ackx, errx, err_acc;
    s = dset(int'(cfg_setup)); p = dpul(int'(cfg_pulse)); c = dcyc(int'(cfg_cycle));
    k = dpul(int'(cfg_cs)); tmax = int'(cfg_timeout); en = cfg_rdy_en;
    l = (c > s + p) ? c : s + p;
    if (l == 0) l = 1;
    t = 0; w = 0; i = 0; err_acc = 0; last_rd = 0;
    req_we = we; req_wide = wide; req_addr = addr; req_wdata = wd; req = 1'b1;
    forever begin
      @(negedge clk);
      bdata_i = 16'(32'hA5C3 ^ (i * 257));
      if (rise >= 0 && i == rise) brdy = 1'b1;
      #1;
      rs   = (rise == -1) ? 1'b1 : (rise >= 0 && i >= rise + 2);
      strb = (t >= s) && (t < s + p);
      lst  = strb && (t == s + p - 1);
      hold = en && lst && !rs && (w != tmax);
      tmo  = en && lst && !rs && (w == tmax);
      ackx = (t == l - 1) && !hold;
      errx = ackx && (err_acc || tmo);
      if (strb && !we) last_rd = int'(bdata_i);
      chk(cs_n == !(t < k), "R3 cs_n", int'(cs_n), int'(!(t < k)));
      chk(rd_n == !(strb && !we), "R1 R4 rd_n", int'(rd_n), int'(!(strb && !we)));
      chk(wr_n == !(strb && we), "R1 R4 wr_n", int'(wr_n), int'(!(strb && we)));
      chk(boe == (we ? {wide, 1'b1} : 2'b00), "R5 oe", int'(boe), int'(we ? {wide, 1'b1} : 2'b00));
      chk(baddr == addr, "R11 addr", int'(baddr), int'(addr));
      if (we) begin
        exp_wd = wide ? int'(wd) : int'(wd) & 255;
        chk(int'(bdata_o) == exp_wd, "R5 wdata", int'(bdata_o), exp_wd);
      end
      chk(ack == ackx, "R2 R8 ack", int'(ack), int'(ackx));
      if (ackx) begin
        chk(err == errx, "R9 err", int'(err), int'(errx));
        if (!we) begin
          exp_rd = wide ? last_rd : last_rd & 255;
          chk(int'(rdata) == exp_rd, "R6 rdata", int'(rdata), exp_rd);
        end
      end
      if (hold) w++; else t++;
      if (tmo) err_acc = 1'b1;
      i++;
      if (ackx || ack) begin
        req = 1'b0;
        break;
      end
      if (i > 3000) begin
        chk(1'b0, "R2 access never ended", i, l);
        req = 1'b0;
        break;
      end
    end
  endtask

  task automatic gap_test(input int f, input bit we);
    int cnt, exp, n;
    cfg_float = 4'(f);
    do_access(we, 1'b1, 24'hC00000, 16'h1234, -1);
    req_we = 1'b0; req_wide = 1'b0; req_addr = 24'hE00006; req = 1'b1;
    cnt = 0; n = 0;
    forever begin
      @(negedge clk); #1;
      if (cs_n && n < 100) begin cnt++; n++; end
      else break;
    end
    forever begin
      if (ack || n > 200) break;
      @(negedge clk); #1; n++;
    end
    req = 1'b0;
    exp = we ? 1 : ((f > 1) ? f : 1);
    chk(cnt == exp, "R7 idle gap", cnt, exp);
    idle(20);
  endtask

  initial begin
    int sc[3];
    int pc[3];
    int cc[4];
    int kc[3];
    int n;
    sc = '{0, 2, 33}; pc = '{1, 3, 64}; cc = '{0, 6, 130, 258}; kc = '{0, 4, 65};
    bdata_i = '0;
    idle(2);
    #1;
    chk(cs_n && rd_n && wr_n, "R10 strobes in reset", int'({cs_n, rd_n, wr_n}), 7);
    chk(boe == 2'b00 && !ack, "R10 oe/ack in reset", int'({boe, ack}), 0);
    rst_n = 1'b1;
    idle(5);
    chk(cs_n && rd_n && wr_n && boe == 2'b00, "R10 idle after reset", int'({cs_n, rd_n, wr_n}), 7);

    // R1 R2 R3 R4 R5 R6 R11: sweep of decoded timing
    cfg_rdy_en = 1'b1;
    n = 0;
    foreach (sc[a]) foreach (pc[b]) foreach (cc[d]) foreach (kc[e]) begin
      cfg_setup = 6'(sc[a]); cfg_pulse = 7'(pc[b]); cfg_cycle = 9'(cc[d]); cfg_cs = 7'(kc[e]);
      do_access(1'b0, n[0], 24'hC00000 + 24'(n & 7), 16'h0, -1);
      idle(2);
      do_access(1'b1, !n[0], 24'hE00006, 16'(16'hBEEF ^ (n * 97)), -1);
      idle(2);
      n++;
    end

    // R7 float gap
    cfg_setup = 6'd1; cfg_pulse = 7'd2; cfg_cycle = 9'd5; cfg_cs = 7'd4;
    gap_test(0, 1'b0);
    gap_test(1, 1'b0);
    gap_test(2, 1'b0);
    gap_test(5, 1'b0);
    gap_test(15, 1'b0);
    gap_test(9, 1'b1);
    cfg_float = '0;

    // R8 R9 ready stretch and limit
    cfg_setup = 6'd2; cfg_pulse = 7'd2; cfg_cycle = 9'd0; cfg_cs = 7'd4;
    cfg_rdy_en = 1'b1; cfg_timeout = 8'd20;
    brdy = 1'b0; idle(3);
    do_access(1'b0, 1'b1, 24'hC00000, 16'h0, 3);
    idle(3);
    brdy = 1'b0; idle(3);
    do_access(1'b1, 1'b0, 24'hC00002, 16'h5A5A, 6);
    idle(3);
    cfg_timeout = 8'd5;
    brdy = 1'b0; idle(3);
    do_access(1'b0, 1'b0, 24'hC00007, 16'h0, -2);
    idle(3);
    cfg_timeout = 8'd0;
    do_access(1'b1, 1'b1, 24'hC00000, 16'hC3C3, -2);
    idle(3);
    cfg_rdy_en = 1'b0; cfg_timeout = 8'd5;
    do_access(1'b0, 1'b1, 24'hE00006, 16'h0, -2);
    idle(3);
    brdy = 1'b1; idle(3);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule